// File: doc/BRIEF.md
# Fetch Block Instruction Aligner

The aligner sits between the instruction cache and the decoder of a core that accepts a mix of 16-bit compressed and 32-bit standard instructions. Each cycle it may receive one 64-bit fetch block together with the PC used to fetch it. It finds where each instruction in the block begins and emits up to four instructions in program order. Each instruction is carried as 32 raw bits, with its PC and a flag that marks it as compressed. Compressed encodings are passed through as they are; expansion is left to the decoder.

The fetch PC may point at any halfword of the block, and halfwords in front of it are skipped. A 32-bit instruction whose first halfword is the last halfword of a block cannot be completed in that cycle. Its lower half is kept in a one-entry holding register. When the next block arrives at the address directly after it, the two halves are joined into the first output slot. If the next block comes from another address, or a redirect flush arrives, the held half is dropped. All outputs are registered, so a block accepted at one clock edge appears on the outputs until the next edge.

Top module: `fetch_aligner`

## Requirements
- R1: After a synchronous reset, out_count is 0, all out_valid bits are 0, and no halfword is held.
- R2: A halfword whose bits [1:0] are not 2'b11 starts a 16-bit instruction. Its slot shows the halfword in instr bits [15:0], zeros in bits [31:16], and rvc = 1. Otherwise the slot holds a 32-bit instruction, formed as {following halfword, this halfword}, with rvc = 0.
- R3: Parsing begins at halfword index in_pc[2:1] of the block, where halfword k is in_blk[16k+15:16k]. Halfwords with a lower index produce no slot. The PC of a slot that starts at halfword k is the block base address (in_pc with bits [2:0] cleared) plus 2k.
- R4: Slots are filled from slot 0 upward in program order. out_count (0 to 4) equals the number of slots filled, and out_valid[i] is 1 exactly when i < out_count. Results appear on the outputs one clock edge after the block is accepted.
- R5: If a 32-bit instruction begins at halfword 3, it gets no slot and its halfword is held, with PC = base + 6. If the next accepted block has in_pc equal to that PC plus 2, slot 0 shows {block halfword 0, held halfword} with the held PC and rvc = 0, and parsing continues at halfword 1.
- R6: If the next accepted block has any other PC, the held halfword is discarded and that block is parsed as if nothing had been held.
- R7: A block presented with flush high produces no slots (out_count 0 on the next cycle) and clears any held halfword.
- R8: In a cycle with in_valid low and flush low, the next outputs show out_count 0, and a held halfword is kept for the next accepted block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Redirect: discard this block and any held halfword |
| in_valid | input | 1 | A fetch block is presented this cycle |
| in_pc | input | PC_W | Fetch PC of the block (halfword aligned) |
| in_blk | input | BLK_W | Fetch block; halfword k at bits [16k+15:16k] |
| out_count | output | CNT_W | Number of filled slots (0..4) |
| out_valid | output | HW | Per-slot valid, filled from slot 0 |
| out_pc | output | HW*PC_W | Per-slot PC; slot i at bits [i*PC_W +: PC_W] |
| out_instr | output | HW*32 | Per-slot raw instruction bits; slot i at [i*32 +: 32] |
| out_rvc | output | HW | Per-slot compressed flag |

## Verification
The bench sweeps all four start halfwords against all sixteen length patterns of a block. Each pattern is run after blocks that leave a half held and after blocks that do not. The next PC is chosen to continue the held half, to skip it, or to jump elsewhere. A design that miscounts the length would shift every later slot by one halfword and give the wrong PCs. A design that joins the halves with the wrong address match would produce a split instruction with a stale lower half, or drop one that should be joined. Flushes and idle cycles are mixed into the sequence to catch a held half that survives a redirect, or one that is lost while the fetch stalls. Each output slot is compared with a reference model in the bench that walks the halfwords one at a time.

// File: rtl/fa_pkg.sv
package fa_pkg;
  typedef logic [15:0] hword_t;

  // Width of one output instruction slot in raw bits.
  localparam int unsigned INSTR_W = 32;

  // Low two bits that mark a full-width encoding.
  localparam logic [1:0] FULL_TAG = 2'b11;
endpackage

// File: rtl/fa_len_detect.sv
// Per-halfword length classification of a fetch block.
module fa_len_detect #(
  parameter int HW = 4
) (
  input  logic [HW*16-1:0] blk,
  output logic [HW-1:0]    is_full
);
  import fa_pkg::*;

  for (genvar i = 0; i < HW; i++) begin : g_hw
    assign is_full[i] = (blk[i*16 +: 2] == FULL_TAG);
  end
endmodule

// File: rtl/fa_parse.sv
// Walks the halfwords of a block from a start index and packs instructions.
module fa_parse #(
  parameter int HW    = 4,
  parameter int PC_W  = 32,
  parameter int CNT_W = 3
) (
  input  logic [HW*16-1:0]   blk,
  input  logic [HW-1:0]      is_full,
  input  logic [PC_W-1:0]    base,
  input  logic [CNT_W-1:0]   first,
  input  logic [CNT_W-1:0]   n0,
  output logic [HW*32-1:0]   slot_bits,
  output logic [HW-1:0]      slot_rvc,
  output logic [HW*PC_W-1:0] slot_pc,
  output logic [CNT_W-1:0]   count,
  output logic               left
);
  localparam int PAD = 2**CNT_W;
  localparam logic [CNT_W-1:0] HW_C   = CNT_W'(HW);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(HW - 1);

  logic [PAD-1:0]      full_pad;
  logic [PAD-1:0]      rvc_w;
  logic [PAD*32-1:0]   bits_w;
  logic [PAD*PC_W-1:0] pc_w;
  logic [CNT_W-1:0]    p;
  logic [CNT_W-1:0]    n;

  assign full_pad = {{(PAD-HW){1'b0}}, is_full};

  always_comb begin
    p      = first;
    n      = n0;
    left   = 1'b0;
    rvc_w  = '0;
    bits_w = '0;
    pc_w   = '0;
    for (int k = 0; k < HW; k++) begin
      if (p < HW_C) begin
        if (!full_pad[p]) begin
          bits_w[n*32 +: 32]    = {16'h0000, blk[p*16 +: 16]};
          rvc_w[n]              = 1'b1;
          pc_w[n*PC_W +: PC_W]  = base + PC_W'({p, 1'b0});
          n = n + 1'b1;
          p = p + 1'b1;
        end else if (p < LAST_C) begin
          bits_w[n*32 +: 32]    = {blk[(p+1)*16 +: 16], blk[p*16 +: 16]};
          rvc_w[n]              = 1'b0;
          pc_w[n*PC_W +: PC_W]  = base + PC_W'({p, 1'b0});
          n = n + 1'b1;
          p = p + 2'd2;
        end else begin
          left = 1'b1;
          p = p + 1'b1;
        end
      end
    end
    count = n;
  end

  assign slot_bits = bits_w[HW*32-1:0];
  assign slot_rvc  = rvc_w[HW-1:0];
  assign slot_pc   = pc_w[HW*PC_W-1:0];
endmodule

// File: rtl/fa_carry.sv
// One-entry holding register for the lower half of a split instruction.
module fa_carry #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            accept,
  input  logic            left,
  input  logic [15:0]     last_hw,
  input  logic [PC_W-1:0] last_pc,
  output logic            pend_v,
  output logic [15:0]     pend_hw,
  output logic [PC_W-1:0] pend_pc
);
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      pend_v  <= 1'b0;
      pend_hw <= '0;
      pend_pc <= '0;
    end else if (accept) begin
      pend_v  <= left;
      pend_hw <= last_hw;
      pend_pc <= last_pc;
    end
  end

  // R7: a redirect leaves nothing held
  a_r7_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> !pend_v);

  // R8: a stalled cycle keeps the held halfword untouched
  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!flush && !accept) |=> ($stable(pend_v) && $stable(pend_hw) && $stable(pend_pc)));
endmodule

// File: rtl/fetch_aligner.sv
module fetch_aligner #(
  parameter int PC_W  = 32,
  parameter int BLK_W = 64,
  localparam int HW    = BLK_W / 16,
  localparam int CNT_W = $clog2(HW + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               in_valid,
  input  logic [PC_W-1:0]    in_pc,
  input  logic [BLK_W-1:0]   in_blk,
  output logic [CNT_W-1:0]   out_count,
  output logic [HW-1:0]      out_valid,
  output logic [HW*PC_W-1:0] out_pc,
  output logic [HW*32-1:0]   out_instr,
  output logic [HW-1:0]      out_rvc
);
  localparam int HSEL_W = $clog2(HW);
  localparam int OFS_W  = HSEL_W + 1;

  logic [HW-1:0]      is_full;
  logic [PC_W-1:0]    base;
  logic               pend_v;
  logic [15:0]        pend_hw;
  logic [PC_W-1:0]    pend_pc;
  logic               joined;
  logic [CNT_W-1:0]   first;
  logic [CNT_W-1:0]   n0;
  logic [HW*32-1:0]   p_bits;
  logic [HW-1:0]      p_rvc;
  logic [HW*PC_W-1:0] p_pc;
  logic [CNT_W-1:0]   p_count;
  logic               p_left;
  logic [HW*32-1:0]   m_bits;
  logic [HW-1:0]      m_rvc;
  logic [HW*PC_W-1:0] m_pc;
  logic               accept;

  assign accept = in_valid && !flush;
  assign base   = {in_pc[PC_W-1:OFS_W], {OFS_W{1'b0}}};
  assign joined = pend_v && (in_pc == pend_pc + PC_W'(2));
  assign first  = joined ? CNT_W'(1) : CNT_W'(in_pc[HSEL_W:1]);
  assign n0     = joined ? CNT_W'(1) : CNT_W'(0);

  fa_len_detect #(.HW(HW)) i_len (
    .blk     (in_blk),
    .is_full (is_full)
  );

  fa_parse #(.HW(HW), .PC_W(PC_W), .CNT_W(CNT_W)) i_parse (
    .blk       (in_blk),
    .is_full   (is_full),
    .base      (base),
    .first     (first),
    .n0        (n0),
    .slot_bits (p_bits),
    .slot_rvc  (p_rvc),
    .slot_pc   (p_pc),
    .count     (p_count),
    .left      (p_left)
  );

  fa_carry #(.PC_W(PC_W)) i_carry (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .accept  (accept),
    .left    (p_left),
    .last_hw (in_blk[BLK_W-1 -: 16]),
    .last_pc (base + PC_W'(2*(HW-1))),
    .pend_v  (pend_v),
    .pend_hw (pend_hw),
    .pend_pc (pend_pc)
  );

  // Slot 0 takes the joined instruction when the held half continues here.
  always_comb begin
    m_bits = p_bits;
    m_rvc  = p_rvc;
    m_pc   = p_pc;
    if (joined) begin
      m_bits[31:0]   = {in_blk[15:0], pend_hw};
      m_rvc[0]       = 1'b0;
      m_pc[PC_W-1:0] = pend_pc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !accept) begin
      out_count <= '0;
      out_valid <= '0;
      out_pc    <= '0;
      out_instr <= '0;
      out_rvc   <= '0;
    end else begin
      out_count <= p_count;
      for (int i = 0; i < HW; i++) begin
        out_valid[i] <= (p_count > CNT_W'(i));
      end
      out_pc    <= m_pc;
      out_instr <= m_bits;
      out_rvc   <= m_rvc;
    end
  end

  // R4: count never exceeds the slot count
  a_r4_count_range: assert property (@(posedge clk) disable iff (rst)
    out_count <= CNT_W'(HW));

  // R7: a flushed block yields no slots
  a_r7_flush_silent: assert property (@(posedge clk) disable iff (rst)
    flush |=> (out_count == '0));

  // R8: no block, no slots
  a_r8_idle_silent: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (out_valid == '0));

  for (genvar i = 0; i < HW; i++) begin : g_chk
    // R4: valid bits agree with the count
    a_r4_valid_thermo: assert property (@(posedge clk) disable iff (rst)
      out_valid[i] == (out_count > CNT_W'(i)));
    // R2: the compressed flag matches the encoding length
    a_r2_len_flag: assert property (@(posedge clk) disable iff (rst)
      out_valid[i] |-> (out_rvc[i] == (out_instr[i*32 +: 2] != 2'b11)));
    if (i + 1 < HW) begin : g_ord
      // R4: adjacent slots are contiguous in the program
      a_r4_pc_order: assert property (@(posedge clk) disable iff (rst)
        out_valid[i+1] |-> (out_pc[(i+1)*PC_W +: PC_W] ==
          out_pc[i*PC_W +: PC_W] + (out_rvc[i] ? PC_W'(2) : PC_W'(4))));
    end
  end
endmodule

// File: tb/test_fetch_aligner.sv
module test_fetch_aligner;
  localparam int CLK_P = 10;
  localparam int PC_W  = 32;
  localparam int BLK_W = 64;
  localparam int HW    = 4;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               flush = 1'b0;
  logic               in_valid = 1'b0;
  logic [PC_W-1:0]    in_pc = '0;
  logic [BLK_W-1:0]   in_blk = '0;
  logic [2:0]         out_count;
  logic [HW-1:0]      out_valid;
  logic [HW*PC_W-1:0] out_pc;
  logic [HW*32-1:0]   out_instr;
  logic [HW-1:0]      out_rvc;

  int n_tests = 0;
  int n_fail  = 0;

  // reference state
  logic        m_pv = 1'b0;
  logic [15:0] m_phw = '0;
  logic [31:0] m_ppc = '0;
  int          e_cnt;
  logic [31:0] e_bits [HW];
  logic [31:0] e_pc   [HW];
  logic        e_rvc  [HW];
  logic        e_join;

  always #(CLK_P/2) clk = ~clk;

  fetch_aligner #(.PC_W(PC_W), .BLK_W(BLK_W)) i_fetch_aligner (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid),
    .in_pc(in_pc), .in_blk(in_blk), .out_count(out_count),
    .out_valid(out_valid), .out_pc(out_pc), .out_instr(out_instr),
    .out_rvc(out_rvc)
  );

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_hw(input int seed, input bit full);
    logic [13:0] body;
    logic [1:0]  lo;
    body = 14'((seed * 2654435 + 12345) >> 3);
    lo   = full ? 2'b11 : 2'(seed % 3);
    return {body, lo};
  endfunction

  function automatic logic [63:0] mk_blk(input int seed, input int pat);
    logic [63:0] b;
    for (int i = 0; i < HW; i++) b[i*16 +: 16] = mk_hw(seed + i * 7, pat[i]);
    return b;
  endfunction

  // Reference: walk halfwords one by one from the requirements.
  task automatic model(input logic v, input logic f, input logic [31:0] pc,
                       input logic [63:0] d);
    int h;
    logic [15:0] hv;
    logic [31:0] bb;
    logic npv;
    e_cnt = 0;
    e_join = 1'b0;
    for (int i = 0; i < HW; i++) begin e_bits[i] = '0; e_pc[i] = '0; e_rvc[i] = 1'b0; end
    if (f) begin
      m_pv = 1'b0;
    end else if (v) begin
      bb = {pc[31:3], 3'b000};
      h = int'(pc[2:1]);
      if (m_pv && pc == m_ppc + 32'd2) begin
        e_bits[0] = {d[15:0], m_phw}; e_pc[0] = m_ppc; e_rvc[0] = 1'b0;
        e_cnt = 1; h = 1; e_join = 1'b1;
      end
      npv = 1'b0;
      while (h < HW) begin
        hv = d[h*16 +: 16];
        if (hv[1:0] != 2'b11) begin
          e_bits[e_cnt] = {16'h0, hv}; e_rvc[e_cnt] = 1'b1;
          e_pc[e_cnt] = bb + 32'(2*h); e_cnt++; h += 1;
        end else if (h == HW - 1) begin
          npv = 1'b1; m_phw = hv; m_ppc = bb + 32'd6; h += 1;
        end else begin
          e_bits[e_cnt] = {d[(h+1)*16 +: 16], hv}; e_rvc[e_cnt] = 1'b0;
          e_pc[e_cnt] = bb + 32'(2*h); e_cnt++; h += 2;
        end
      end
      m_pv = npv;
    end
  endtask

  task automatic step(input logic v, input logic f, input logic [31:0] pc,
                      input logic [63:0] d, input string tag);
    @(negedge clk);
    in_valid = v; flush = f; in_pc = pc; in_blk = d;
    model(v, f, pc, d);
    @(posedge clk);
    #1;
    check(tag, "count", 64'(out_count), 64'(e_cnt));
    for (int i = 0; i < HW; i++) begin
      check(tag, "valid", 64'(out_valid[i]), 64'(i < e_cnt));
      if (i < e_cnt) begin
        check((i == 0 && e_join) ? "R5" : "R2", "instr", 64'(out_instr[i*32 +: 32]), 64'(e_bits[i]));
        check((i == 0 && e_join) ? "R5" : "R2", "rvc", 64'(out_rvc[i]), 64'(e_rvc[i]));
        check((i == 0 && e_join) ? "R5" : "R3", "pc", 64'(out_pc[i*PC_W +: PC_W]), 64'(e_pc[i]));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] addr;
    int seed;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", "count", 64'(out_count), 64'd0);
    check("R1", "valid", 64'(out_valid), 64'd0);
    @(negedge clk); rst = 1'b0;

    // R3: start at last halfword, 16-bit there
    step(1'b1, 1'b0, 32'h1006, mk_blk(5, 4'b0000), "R3");
    // R5: split instruction, then continuation
    step(1'b1, 1'b0, 32'h2000, mk_blk(9, 4'b1000), "R5");
    step(1'b1, 1'b0, 32'h2008, mk_blk(13, 4'b0000), "R5");
    // R6: split, then a jump elsewhere
    step(1'b1, 1'b0, 32'h3000, mk_blk(17, 4'b1000), "R6");
    step(1'b1, 1'b0, 32'h4008, mk_blk(21, 4'b0001), "R6");
    // R8: stall keeps held half
    step(1'b1, 1'b0, 32'h5004, mk_blk(25, 4'b1000), "R8");
    step(1'b0, 1'b0, 32'h0000, 64'h0, "R8");
    step(1'b1, 1'b0, 32'h5008, mk_blk(29, 4'b0000), "R8");
    // R7: flush drops held half and its own block
    step(1'b1, 1'b0, 32'h6000, mk_blk(33, 4'b1000), "R7");
    step(1'b1, 1'b1, 32'h6008, mk_blk(37, 4'b0000), "R7");
    step(1'b1, 1'b0, 32'h6008, mk_blk(41, 4'b0000), "R7");

    // R4: sweep start x length pattern x next-PC choice
    addr = 32'h8000;
    seed = 100;
    for (int s = 0; s < HW; s++) begin
      for (int pat = 0; pat < 16; pat++) begin
        for (int var_k = 0; var_k < 3; var_k++) begin
          logic [31:0] pc;
          if (var_k == 0 && m_pv) pc = m_ppc + 32'd2;
          else if (var_k == 2) pc = addr + 32'h100 + 32'(2*s);
          else pc = addr + 32'(2*s);
          step(1'b1, 1'b0, pc, mk_blk(seed, pat), "R4");
          addr = {pc[31:3], 3'b000} + 32'd8;
          seed += 11;
          if ((seed % 7) == 0) step(1'b0, 1'b0, 32'h0, 64'h0, "R8");
          if ((seed % 13) == 0) step(1'b1, 1'b1, addr, mk_blk(seed, pat), "R7");
        end
      end
    end

    @(negedge clk);
    in_valid = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule